// File: doc/BRIEF.md
# Shaper Rate Mantissa-Exponent Encoder

This block turns two shaping rates (a guaranteed minimum and a ceiling) into a compact code for a transmit-queue shaper. The code is a 7-bit mantissa scaled by a power of ten, and it is paired with an enable flag. The block then builds two register words for one queue. The scheduling word holds both rate codes, the weight and the scheduler choice. The reservation word carries the reserve count. Bits of the old register contents that the update does not own are passed through unchanged.

The reduction is done one step per clock. While a rate is above 127 it is divided by ten, by a multiply with a constant reciprocal, and its exponent goes up by one. Both rates are reduced side by side. A one-cycle done pulse appears once the slower of the two has finished. The caller presents the inputs together with a one-cycle start strobe. It then waits for done and takes the two words, which hold their value until the next completed request.

Top module: `shaper_enc_top`

## Requirements
- R1: A nonzero rate is encoded by dividing it by ten (integer division) for as long as it exceeds 127. The exponent is the number of divisions and the mantissa is the value that remains. Whenever the exponent is nonzero, the mantissa is at least 12.
- R2: In the scheduling word, bit 11 is set when the maximum rate is nonzero. Bits 10:4 hold the maximum-rate mantissa and bits 3:0 hold its exponent.
- R3: In the scheduling word, bit 27 is set when the minimum rate is nonzero. Bits 26:20 hold the minimum-rate mantissa and bits 19:16 hold its exponent.
- R4: Bits 15:12 of the scheduling word carry the 4-bit weight, and bit 31 carries the scheduler select.
- R5: Bits 30:28 of the scheduling word are copied from the old scheduling word given with the start.
- R6: In the configuration word, the 8-bit reserve value is written to both bits 15:8 and bits 7:0. Bits 31:16 are copied from the old configuration word.
- R7: A start with a queue id of 16 or more is ignored. No done pulse follows and both output words keep their value.
- R8: A rate of zero encodes to a zero mantissa, a zero exponent and a cleared enable bit.
- R9: Let M be the larger division count of the two rates. Done is high for exactly one cycle, and that cycle begins M+1 clock edges after the edge that accepts start. The output words change only at the edge that raises done.
- R10: A start that arrives while a request is still being encoded is ignored. The result reflects the accepted request only, and no extra done pulse follows.
- R11: After reset, done is low and both output words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request strobe |
| queue_id_i | input | QID_W | Target queue; only ids below 16 are valid |
| sched_sel_i | input | 1 | Scheduler select, goes to scheduling word bit 31 |
| weight_i | input | 4 | Queue weight |
| reserve_i | input | 8 | Reserve count |
| min_rate_i | input | 32 | Minimum rate |
| max_rate_i | input | 32 | Maximum rate |
| old_sched_i | input | 32 | Current scheduling word contents |
| old_cfg_i | input | 32 | Current configuration word contents |
| sched_word_o | output | 32 | New scheduling word |
| cfg_word_o | output | 32 | New configuration word |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a second start that lands in the middle of a long encode. It must be lost, and neither the inputs captured for the first request nor the number of cycles that request takes may change. To reach it, the stimulus starts a request with rates near the top of the 32-bit range, which need eight divisions. Three cycles later it changes every input and pulses start again. It then checks the latency and the fields against the first request and watches for a stray second done. Random rates are drawn with random magnitudes so that every division count from zero to eight occurs, and each exponent boundary (127/128, 1279/1280) is also driven directly.

// File: rtl/shaper_enc_pkg.sv
package shaper_enc_pkg;

    localparam int RATE_W     = 32;
    localparam int MANT_W     = 7;
    localparam int EXP_W      = 4;
    localparam int WEIGHT_W   = 4;
    localparam int RESV_W     = 8;
    localparam int WORD_W     = 32;
    localparam int NUM_QUEUES = 16;
    localparam int NUM_RATES  = 2;   // index 0: minimum, index 1: maximum
    localparam int KEEP_HI    = 30;  // top of preserved scheduling bits
    localparam int KEEP_LO    = 28;
    localparam int CFG_KEEP_LO = 16;

    localparam logic [RATE_W-1:0] MANT_LIMIT = RATE_W'((1 << MANT_W) - 1);

    // Exact floor(x/10) for all 32-bit x via reciprocal multiply.
    localparam logic [2*RATE_W-1:0] DIV10_RECIP = 64'h0000_0000_CCCC_CCCD;
    localparam int                  DIV10_SHIFT = 35;

    typedef struct packed {
        logic              en;
        logic [MANT_W-1:0] mant;
        logic [EXP_W-1:0]  expo;
    } rate_code_t;

    typedef struct packed {
        logic                sched;
        logic [WEIGHT_W-1:0] weight;
        logic [RESV_W-1:0]   resv;
        logic [WORD_W-1:0]   old_sched;
        logic [WORD_W-1:0]   old_cfg;
    } req_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } enc_state_t;

    function automatic logic [RATE_W-1:0] div_by_ten(input logic [RATE_W-1:0] x);
        logic [2*RATE_W-1:0] prod;
        prod = (2*RATE_W)'(x) * DIV10_RECIP;
        return RATE_W'(prod >> DIV10_SHIFT);
    endfunction

endpackage

// File: rtl/shaper_rate_encoder.sv
module shaper_rate_encoder
    import shaper_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              fin_o,
    output rate_code_t        code_o
);

    logic [RATE_W-1:0] val_q;
    logic [EXP_W-1:0]  exp_q;
    logic              nz_q;
    logic              fits;

    assign fits = (val_q <= MANT_LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
            exp_q <= '0;
            nz_q  <= 1'b0;
        end else if (load_i) begin
            val_q <= rate_i;
            exp_q <= '0;
            nz_q  <= (rate_i != '0);
        end else if (!fits) begin
            val_q <= div_by_ten(val_q);
            exp_q <= exp_q + 1'b1;
        end
    end

    assign fin_o       = fits;
    assign code_o.en   = nz_q;
    assign code_o.mant = val_q[MANT_W-1:0];
    assign code_o.expo = exp_q;

endmodule

// File: rtl/shaper_word_pack.sv
module shaper_word_pack
    import shaper_enc_pkg::*;
(
    input  req_t              req_i,
    input  rate_code_t        min_code_i,
    input  rate_code_t        max_code_i,
    output logic [WORD_W-1:0] sched_word_o,
    output logic [WORD_W-1:0] cfg_word_o
);

    always_comb begin
        sched_word_o = {req_i.sched,
                        req_i.old_sched[KEEP_HI:KEEP_LO],
                        min_code_i,
                        req_i.weight,
                        max_code_i};
        cfg_word_o   = {req_i.old_cfg[WORD_W-1:CFG_KEEP_LO],
                        req_i.resv,
                        req_i.resv};
    end

endmodule

// File: rtl/shaper_enc_top.sv
module shaper_enc_top
    import shaper_enc_pkg::*;
#(
    parameter int QID_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [QID_W-1:0]    queue_id_i,
    input  logic                sched_sel_i,
    input  logic [WEIGHT_W-1:0] weight_i,
    input  logic [RESV_W-1:0]   reserve_i,
    input  logic [RATE_W-1:0]   min_rate_i,
    input  logic [RATE_W-1:0]   max_rate_i,
    input  logic [WORD_W-1:0]   old_sched_i,
    input  logic [WORD_W-1:0]   old_cfg_i,
    output logic [WORD_W-1:0]   sched_word_o,
    output logic [WORD_W-1:0]   cfg_word_o,
    output logic                done_o
);

    enc_state_t        state_q;
    req_t              req_q;
    logic              id_ok;
    logic              accept;
    logic [RATE_W-1:0] rate_in [NUM_RATES];
    rate_code_t        codes   [NUM_RATES];
    logic [NUM_RATES-1:0] fin;
    logic [WORD_W-1:0] sched_next;
    logic [WORD_W-1:0] cfg_next;

    assign id_ok  = (32'(queue_id_i) < 32'(NUM_QUEUES));
    assign accept = (state_q == ST_IDLE) && start_i && id_ok;

    assign rate_in[0] = min_rate_i;
    assign rate_in[1] = max_rate_i;

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_enc
        shaper_rate_encoder u_enc (
            .clk    (clk),
            .rst    (rst),
            .load_i (accept),
            .rate_i (rate_in[g]),
            .fin_o  (fin[g]),
            .code_o (codes[g])
        );
    end

    shaper_word_pack u_pack (
        .req_i        (req_q),
        .min_code_i   (codes[0]),
        .max_code_i   (codes[1]),
        .sched_word_o (sched_next),
        .cfg_word_o   (cfg_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            req_q        <= '0;
            sched_word_o <= '0;
            cfg_word_o   <= '0;
            done_o       <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        req_q.sched     <= sched_sel_i;
                        req_q.weight    <= weight_i;
                        req_q.resv      <= reserve_i;
                        req_q.old_sched <= old_sched_i;
                        req_q.old_cfg   <= old_cfg_i;
                        state_q         <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (&fin) begin
                        sched_word_o <= sched_next;
                        cfg_word_o   <= cfg_next;
                        done_o       <= 1'b1;
                        state_q      <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

module shaper_enc_checker
    import shaper_enc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              done_o,
    input logic [WORD_W-1:0] sched_word_o,
    input logic [WORD_W-1:0] cfg_word_o
);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9
    words_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(sched_word_o) && $stable(cfg_word_o)));

    // R2
    max_en_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (sched_word_o[11] == (sched_word_o[10:4] != '0)));

    // R3
    min_en_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (sched_word_o[27] == (sched_word_o[26:20] != '0)));

    // R1
    mant_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && sched_word_o[3:0] != '0) |-> (sched_word_o[10:4] >= 7'd12));

    // R6
    resv_dup_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cfg_word_o[15:8] == cfg_word_o[7:0]));

endmodule

bind shaper_enc_top shaper_enc_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .done_o       (done_o),
    .sched_word_o (sched_word_o),
    .cfg_word_o   (cfg_word_o)
);

// File: tb/tb_shaper_enc_top.sv
module tb_shaper_enc_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [4:0]  queue_id_i;
    logic        sched_sel_i;
    logic [3:0]  weight_i;
    logic [7:0]  reserve_i;
    logic [31:0] min_rate_i, max_rate_i, old_sched_i, old_cfg_i;
    logic [31:0] sched_word_o, cfg_word_o;
    logic        done_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    shaper_enc_top #(.QID_W(5)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .queue_id_i(queue_id_i),
        .sched_sel_i(sched_sel_i), .weight_i(weight_i), .reserve_i(reserve_i),
        .min_rate_i(min_rate_i), .max_rate_i(max_rate_i),
        .old_sched_i(old_sched_i), .old_cfg_i(old_cfg_i),
        .sched_word_o(sched_word_o), .cfg_word_o(cfg_word_o), .done_o(done_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic int div_count(input logic [31:0] r);
        int n = 0;
        logic [31:0] v = r;
        while (v > 127) begin v = v / 10; n++; end
        return n;
    endfunction

    function automatic logic [11:0] code_of(input logic [31:0] r);
        logic [31:0] v = r;
        logic [3:0]  e = 0;
        while (v > 127) begin v = v / 10; e++; end
        return {r != 0, v[6:0], e};
    endfunction

    // Runs one valid request; checks every field, latency and pulse width.
    task automatic run_req(input logic [31:0] mn, input logic [31:0] mx,
                           input logic sel, input logic [3:0] w, input logic [7:0] rv,
                           input logic [31:0] os, input logic [31:0] oc, input logic [4:0] qid,
                           input bit poke_busy);
        int m, cnt;
        logic [31:0] es, ec;
        m  = (div_count(mn) > div_count(mx)) ? div_count(mn) : div_count(mx);
        es = {sel, os[30:28], code_of(mn), w, code_of(mx)};
        ec = {oc[31:16], rv, rv};
        @(negedge clk);
        start_i = 1; queue_id_i = qid; sched_sel_i = sel; weight_i = w; reserve_i = rv;
        min_rate_i = mn; max_rate_i = mx; old_sched_i = os; old_cfg_i = oc;
        cnt = 0;
        do begin
            @(posedge clk); cnt++;
            @(negedge clk);
            start_i = 0;
            if (poke_busy && cnt == 3) begin
                // R10: second start mid-encode with altered inputs
                start_i = 1; min_rate_i = 5; max_rate_i = 0; sched_sel_i = ~sel;
                weight_i = ~w; reserve_i = ~rv; old_sched_i = ~os; old_cfg_i = ~oc;
            end
        end while (!done_o && cnt < 40);
        start_i = 0;
        check(poke_busy ? "R9 R10 latency" : "R9 latency", 32'(cnt), 32'(m + 2));
        check("R1 R2 max field", {20'b0, sched_word_o[11:0]}, {20'b0, es[11:0]});
        check("R1 R3 min field", {20'b0, sched_word_o[27:16]}, {20'b0, es[27:16]});
        check("R4 weight sel", {27'b0, sched_word_o[31], sched_word_o[15:12]}, {27'b0, es[31], es[15:12]});
        check("R5 kept bits", {29'b0, sched_word_o[30:28]}, {29'b0, es[30:28]});
        check("R6 cfg word", cfg_word_o, ec);
        @(negedge clk);
        check("R9 pulse width", {31'b0, done_o}, 32'd0);
        if (poke_busy) begin
            for (int i = 0; i < 15; i++) begin
                @(negedge clk);
                check("R10 no extra done", {31'b0, done_o}, 32'd0);
            end
        end
    endtask

    initial begin
        #1_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] s0, c0;
        void'($urandom(32'd20240611));
        rst = 1; start_i = 0; queue_id_i = 0; sched_sel_i = 0; weight_i = 0;
        reserve_i = 0; min_rate_i = 0; max_rate_i = 0; old_sched_i = 0; old_cfg_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        @(negedge clk);
        check("R11 reset done", {31'b0, done_o}, 32'd0);
        check("R11 reset sched", sched_word_o, 32'd0);
        check("R11 reset cfg", cfg_word_o, 32'd0);

        // R8: zero rates
        run_req(0, 0, 1'b1, 4'hA, 8'h5C, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, 0);
        // R1 boundaries
        run_req(127, 128, 1'b0, 4'h7, 8'h20, 32'h7000_0000, 32'h1234_0000, 5'd15, 0);
        run_req(1279, 1280, 1'b1, 4'h0, 8'hFF, 32'h5000_0000, 32'hABCD_9999, 5'd1, 0);
        run_req(32'hFFFF_FFFF, 1, 1'b0, 4'hF, 8'h01, 32'h0, 32'h0, 5'd8, 0);
        run_req(250000, 0, 1'b0, 4'd7, 8'd32, 32'h3000_0000, 32'h0, 5'd9, 0);

        // R7: invalid queue id
        s0 = sched_word_o; c0 = cfg_word_o;
        @(negedge clk);
        start_i = 1; queue_id_i = 5'd20; min_rate_i = 999; max_rate_i = 77;
        reserve_i = 8'h11; weight_i = 4'h3;
        @(negedge clk); start_i = 0;
        for (int i = 0; i < 20; i++) begin
            if (done_o) begin
                n_checks++; n_fail++;
                $display("FAIL R7 done actual=1 expected=0");
            end
            @(negedge clk);
        end
        check("R7 sched held", sched_word_o, s0);
        check("R7 cfg held", cfg_word_o, c0);
        queue_id_i = 0;

        // R10: start while busy
        run_req(32'hFFFF_FFF0, 32'hF000_0000, 1'b1, 4'h9, 8'hA5, 32'h6000_0000, 32'h8888_0000, 5'd3, 1);

        // Random requests
        for (int k = 0; k < 60; k++) begin
            logic [31:0] a, b;
            a = $urandom >> ($urandom % 32);
            b = $urandom >> ($urandom % 32);
            if ($urandom % 8 == 0) a = 0;
            run_req(a, b, 1'($urandom), 4'($urandom), 8'($urandom),
                    $urandom, $urandom, 5'($urandom % 16), 0);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule